// File: doc/BRIEF.md
# Prioritized Address Window Translator

This block turns a local-bus address into a PCI bus address, a PCI cycle type and a prefetch flag. It holds three programmable windows. Each window has a base register that sets where it matches, how large it is, whether it is prefetchable and whether it is on. Each window also has a map register that gives the upper bits of the translated address, the cycle type and the handling of address bits 1..0. Windows 0 and 1 are memory-style windows with a size code from 1 MB to 2 GB. Window 2 is a fixed 16 MB I/O window.

The windows are searched in ascending index order and the first enabled match wins. Software can therefore overlap windows on purpose. A common case is to enlarge window 0 so that it covers window 1, reprogram window 1 (for example for configuration cycles), and then shrink window 0 again. Software programs the windows through a small write/read register port. A translation request is answered one clock later on a registered response.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset every register reads 0, and all response outputs are 0 until a request arrives.
- R2: Register index 2*w selects the base register of window w and index 2*w+1 selects its map register (w = 0..2). Indices 6 and 7 read 0 and ignore writes. Reads return only the stored bits. For windows 0 and 1 the base register keeps mask 0xFFF000F9 and the map register keeps 0xFFFF. For window 2 the base register keeps 0xFF09 and the map register keeps 0xFF0F. A write takes effect at the next clock edge, and a request in the same cycle as a write is translated with the old values.
- R3: Window 0 and window 1 each cover 2^(20+code) bytes, where code is base bits 7..4 (code 0 gives 1 MB, code 11 gives 2 GB). An address matches when its bits from 20+code up to 31 equal the same bits of the base register.
- R4: A window with base bit 0 clear never matches. For windows 0 and 1, size codes 12 to 15 also make the window never match.
- R5: When several enabled windows match, the one with the lowest index is reported.
- R6: On a hit, translated bits at and above the window's size boundary come from the map register (map bits 15..4 give PCI bits 31..20 for windows 0 and 1). Bits below the boundary pass through from the local address.
- R7: Map bit 0 set copies local address bits 1..0 into the translated address. Map bit 0 clear forces those two bits to 0.
- R8: On a hit, rspCycle equals map bits 3..1 (000 interrupt acknowledge, 001 I/O, 011 memory, 101 configuration, 110 memory-multiple), and rspPrefetch equals base bit 3 of the winning window.
- R9: Window 2 matches when local bits 31..24 equal base bits 15..8. Its translated bits 31..24 come from map bits 15..8, and bits 23..2 pass through.
- R10: A request that matches no window gives rspHit, rspWin, rspAddr, rspCycle and rspPrefetch all 0.
- R11: rspValid follows reqValid one clock later. When no request is made, every response output is 0.
- R12: Setting window 0 to 512 MB over a range that contains window 1 routes window 1's addresses through window 0. Shrinking window 0 back to 256 MB makes them reach window 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| reqValid | input | 1 | Translation request |
| reqAddr | input | 32 | Local address to translate |
| rspValid | output | 1 | Response valid, one clock after the request |
| rspHit | output | 1 | Some window matched |
| rspWin | output | 2 | Index of the winning window |
| rspAddr | output | 32 | Translated PCI address |
| rspCycle | output | 3 | PCI cycle-type code |
| rspPrefetch | output | 1 | Winning window is prefetchable |

## Verification
The bench drives addresses that sit exactly at the edge of each window size. A design with an off-by-one in the size shift would hit or miss one megabyte-doubling too far at those addresses. It builds overlapping windows and swaps their sizes; a priority encoder that favours the highest index would report window 1 where window 0 is expected. It also sets reserved size codes, clears enable bits and clears the low-bit control. A design that decoded code 12 as 4 GB, or passed bits 1..0 through unconditionally, would then produce hits or address bits that the model does not. Finally, writes that land in the same cycle as a request check that the design does not forward the new values early.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int ADDR_W = 32;

  // Decoded view of one window, handed from control to datapath
  typedef struct packed {
    logic              active;
    logic [ADDR_W-1:0] hiMask;
    logic [ADDR_W-1:0] baseAddr;
    logic [ADDR_W-1:0] mapAddr;
    logic              prefetch;
    logic [2:0]        cycType;
    logic              lowEn;
  } winCfg_t;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs
  import xlate_pkg::*;
#(
  parameter int NUM_WIN   = 3,
  parameter int MIN_SHIFT = 20,
  parameter int MAX_CODE  = 11,
  parameter int IO_SHIFT  = 24,
  parameter int REG_AW    = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWe,
  input  logic [REG_AW-1:0]       regAddr,
  input  logic [ADDR_W-1:0]       regWdata,
  output logic [ADDR_W-1:0]       regRdata,
  output winCfg_t [NUM_WIN-1:0]   cfg
);
  localparam int MAP_W  = 16;
  localparam int MEM_FW = ADDR_W - MIN_SHIFT;
  localparam int IO_FW  = ADDR_W - IO_SHIFT;
  localparam logic [ADDR_W-1:0] MEM_BASE_MASK =
    {{MEM_FW{1'b1}}, {(MIN_SHIFT-8){1'b0}}, 8'hF9};
  localparam logic [ADDR_W-1:0] IO_BASE_MASK = ADDR_W'(16'hFF09);
  localparam logic [MAP_W-1:0]  MEM_MAP_MASK = 16'hFFFF;
  localparam logic [MAP_W-1:0]  IO_MAP_MASK  = 16'hFF0F;

  logic [ADDR_W-1:0] baseReg [NUM_WIN];
  logic [MAP_W-1:0]  mapReg  [NUM_WIN];

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : gWin
      localparam bit IS_IO = (w == NUM_WIN - 1);
      localparam logic [ADDR_W-1:0] B_MASK = IS_IO ? IO_BASE_MASK : MEM_BASE_MASK;
      localparam logic [MAP_W-1:0]  M_MASK = IS_IO ? IO_MAP_MASK : MEM_MAP_MASK;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          baseReg[w] <= '0;
          mapReg[w]  <= '0;
        end else if (regWe) begin
          if (regAddr == REG_AW'(2*w))     baseReg[w] <= regWdata & B_MASK;
          if (regAddr == REG_AW'(2*w + 1)) mapReg[w]  <= regWdata[MAP_W-1:0] & M_MASK;
        end
      end

      if (IS_IO) begin : gIo
        always_comb begin
          cfg[w].active   = baseReg[w][0];
          cfg[w].hiMask   = {ADDR_W{1'b1}} << IO_SHIFT;
          cfg[w].baseAddr = {baseReg[w][MAP_W-1 -: IO_FW], {IO_SHIFT{1'b0}}};
          cfg[w].mapAddr  = {mapReg[w][MAP_W-1 -: IO_FW], {IO_SHIFT{1'b0}}};
        end
      end else begin : gMem
        logic [3:0] sizeCode;
        assign sizeCode = baseReg[w][7:4];
        always_comb begin
          cfg[w].active   = baseReg[w][0] && (int'(sizeCode) <= MAX_CODE);
          cfg[w].hiMask   = {ADDR_W{1'b1}} << (MIN_SHIFT + int'(sizeCode));
          cfg[w].baseAddr = {baseReg[w][ADDR_W-1 -: MEM_FW], {MIN_SHIFT{1'b0}}};
          cfg[w].mapAddr  = {mapReg[w][MAP_W-1 -: MEM_FW], {MIN_SHIFT{1'b0}}};
        end
      end

      assign cfg[w].prefetch = baseReg[w][3];
      assign cfg[w].cycType  = mapReg[w][3:1];
      assign cfg[w].lowEn    = mapReg[w][0];

      // Registers hold their value without a write strobe
      assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
        !regWe |=> ($stable(baseReg[w]) && $stable(mapReg[w])));
    end
  endgenerate

  always_comb begin
    regRdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (regAddr == REG_AW'(2*w))     regRdata = baseReg[w];
      if (regAddr == REG_AW'(2*w + 1)) regRdata = ADDR_W'(mapReg[w]);
    end
  end
endmodule

// File: rtl/xlate_match.sv
module xlate_match
  import xlate_pkg::*;
#(
  parameter int NUM_WIN = 3,
  parameter int WIN_W   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  winCfg_t [NUM_WIN-1:0] cfg,
  output logic                  rspValid,
  output logic                  rspHit,
  output logic [WIN_W-1:0]      rspWin,
  output logic [ADDR_W-1:0]     rspAddr,
  output logic [2:0]            rspCycle,
  output logic                  rspPrefetch
);
  logic [NUM_WIN-1:0] hitVec;
  logic               anyHit;
  logic [WIN_W-1:0]   selIdx;
  winCfg_t            selCfg;
  logic [ADDR_W-1:0]  xAddr;

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : gCmp
      assign hitVec[w] = cfg[w].active &&
        (((reqAddr ^ cfg[w].baseAddr) & cfg[w].hiMask) == '0);
    end
  endgenerate

  // Lowest index wins: scan downward, last assignment sticks
  always_comb begin
    anyHit = 1'b0;
    selIdx = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hitVec[w]) begin
        anyHit = 1'b1;
        selIdx = WIN_W'(w);
      end
    end
  end

  assign selCfg = cfg[selIdx];

  always_comb begin
    xAddr = (selCfg.mapAddr & selCfg.hiMask) | (reqAddr & ~selCfg.hiMask);
    xAddr[1:0] = selCfg.lowEn ? reqAddr[1:0] : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspWin      <= '0;
      rspAddr     <= '0;
      rspCycle    <= '0;
      rspPrefetch <= 1'b0;
    end else begin
      rspValid <= reqValid;
      if (reqValid && anyHit) begin
        rspHit      <= 1'b1;
        rspWin      <= selIdx;
        rspAddr     <= xAddr;
        rspCycle    <= selCfg.cycType;
        rspPrefetch <= selCfg.prefetch;
      end else begin
        rspHit      <= 1'b0;
        rspWin      <= '0;
        rspAddr     <= '0;
        rspCycle    <= '0;
        rspPrefetch <= 1'b0;
      end
    end
  end

  assert_first_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && hitVec[0]) |=> (rspHit && rspWin == '0));

  assert_miss_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && hitVec == '0) |=> (!rspHit && rspAddr == '0 && rspCycle == '0 && !rspPrefetch));

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspHit));

  assert_low_bits_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && anyHit && !selCfg.lowEn) |=> (rspAddr[1:0] == 2'b00));
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
  import xlate_pkg::*;
#(
  parameter int NUM_WIN   = 3,
  parameter int MIN_SHIFT = 20,
  parameter int MAX_CODE  = 11,
  parameter int IO_SHIFT  = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  output logic        rspValid,
  output logic        rspHit,
  output logic [1:0]  rspWin,
  output logic [31:0] rspAddr,
  output logic [2:0]  rspCycle,
  output logic        rspPrefetch
);
  localparam int REG_AW = 3;
  localparam int WIN_W  = 2;

  winCfg_t [NUM_WIN-1:0] cfg;

  xlate_regs #(
    .NUM_WIN(NUM_WIN), .MIN_SHIFT(MIN_SHIFT), .MAX_CODE(MAX_CODE),
    .IO_SHIFT(IO_SHIFT), .REG_AW(REG_AW)
  ) uRegs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cfg(cfg)
  );

  xlate_match #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) uMatch (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .cfg(cfg),
    .rspValid(rspValid), .rspHit(rspHit), .rspWin(rspWin), .rspAddr(rspAddr),
    .rspCycle(rspCycle), .rspPrefetch(rspPrefetch)
  );
endmodule

// File: tb/tb_addr_window_xlate.sv
module tb_addr_window_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        rspValid, rspHit, rspPrefetch;
  logic [1:0]  rspWin;
  logic [31:0] rspAddr;
  logic [2:0]  rspCycle;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  logic [31:0] shBase [3];
  logic [15:0] shMap  [3];

  always #5 clk = ~clk;

  addr_window_xlate dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .reqValid(reqValid), .reqAddr(reqAddr), .rspValid(rspValid),
    .rspHit(rspHit), .rspWin(rspWin), .rspAddr(rspAddr), .rspCycle(rspCycle),
    .rspPrefetch(rspPrefetch)
  );

  // Storage masks from R2
  function automatic logic [31:0] baseMask(input int w);
    return (w == 2) ? 32'h0000FF09 : 32'hFFF000F9;
  endfunction
  function automatic logic [15:0] mapMask(input int w);
    return (w == 2) ? 16'hFF0F : 16'hFFFF;
  endfunction

  // Reference translation from R3..R10
  function automatic void model(input logic [31:0] a, output logic h, output logic [1:0] wi,
                                output logic [31:0] pa, output logic [2:0] cy, output logic pf);
    h = 1'b0; wi = 2'd0; pa = '0; cy = '0; pf = 1'b0;
    for (int w = 2; w >= 0; w--) begin
      logic [31:0] hm;
      logic        m;
      logic [31:0] mb;
      int          code;
      code = int'(shBase[w][7:4]);
      if (w == 2) begin
        hm = 32'hFF000000;
        m  = shBase[w][0] && (a[31:24] == shBase[w][15:8]);
        mb = {shMap[w][15:8], 24'h0};
      end else begin
        hm = (code <= 11) ? (32'hFFFFFFFF << (20 + code)) : 32'h0;
        m  = shBase[w][0] && (code <= 11) &&
             (((a ^ {shBase[w][31:20], 20'h0}) & hm) == 32'h0);
        mb = {shMap[w][15:4], 20'h0};
      end
      if (m) begin
        h  = 1'b1;
        wi = 2'(w);
        pa = (mb & hm) | (a & ~hm);
        pa[1:0] = shMap[w][0] ? a[1:0] : 2'b00;
        cy = shMap[w][3:1];
        pf = shBase[w][3];
      end
    end
  endfunction

  task automatic shadowWrite(input logic [2:0] ra, input logic [31:0] d);
    if (ra < 3'd6) begin
      if (ra[0]) shMap[ra >> 1]  = d[15:0] & mapMask(int'(ra >> 1));
      else       shBase[ra >> 1] = d & baseMask(int'(ra >> 1));
    end
  endtask

  task automatic regWrite(input logic [2:0] ra, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = ra; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    shadowWrite(ra, d);
  endtask

  task automatic checkRead(input string tag, input logic [2:0] ra);
    logic [31:0] exp;
    @(negedge clk);
    regAddr = ra;
    #1;
    if (ra >= 3'd6) exp = '0;
    else if (ra[0]) exp = {16'h0, shMap[ra >> 1]};
    else exp = shBase[ra >> 1];
    nVec++;
    if (regRdata !== exp) begin
      nBad++;
      $display("FAIL %s: reg %0d read actual %08h expected %08h", tag, ra, regRdata, exp);
    end
  endtask

  task automatic compareRsp(input string tag, input logic [31:0] a, input logic h,
                            input logic [1:0] wi, input logic [31:0] pa,
                            input logic [2:0] cy, input logic pf);
    nVec++;
    if (rspValid !== 1'b1 || rspHit !== h || rspWin !== wi || rspAddr !== pa ||
        rspCycle !== cy || rspPrefetch !== pf) begin
      nBad++;
      $display("FAIL %s: addr %08h actual v=%b h=%b w=%0d a=%08h c=%03b p=%b expected v=1 h=%b w=%0d a=%08h c=%03b p=%b",
               tag, a, rspValid, rspHit, rspWin, rspAddr, rspCycle, rspPrefetch,
               h, wi, pa, cy, pf);
    end
  endtask

  task automatic probe(input string tag, input logic [31:0] a);
    logic h, pf; logic [1:0] wi; logic [31:0] pa; logic [2:0] cy;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    model(a, h, wi, pa, cy, pf);
    @(negedge clk);
    reqValid = 1'b0;
    compareRsp(tag, a, h, wi, pa, cy, pf);
  endtask

  // Write and request in the same cycle: old values apply (R2)
  task automatic writeWithProbe(input logic [2:0] ra, input logic [31:0] d, input logic [31:0] a);
    logic h, pf; logic [1:0] wi; logic [31:0] pa; logic [2:0] cy;
    @(negedge clk);
    regWe = 1'b1; regAddr = ra; regWdata = d;
    reqValid = 1'b1; reqAddr = a;
    model(a, h, wi, pa, cy, pf);
    @(negedge clk);
    regWe = 1'b0; reqValid = 1'b0;
    shadowWrite(ra, d);
    compareRsp("R2 same-cycle old values", a, h, wi, pa, cy, pf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 3; w++) begin shBase[w] = '0; shMap[w] = '0; end
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    nVec++;
    if (rspValid !== 1'b0 || rspHit !== 1'b0 || rspAddr !== 32'h0 || rspCycle !== 3'h0 ||
        rspPrefetch !== 1'b0 || rspWin !== 2'd0) begin
      nBad++;
      $display("FAIL R1: reset outputs actual v=%b h=%b a=%08h expected all zero",
               rspValid, rspHit, rspAddr);
    end
    for (int r = 0; r < 8; r++) checkRead("R1 reset readback", 3'(r));
    probe("R1 R10 no window enabled", 32'h40000000);

    // R2 masks, unused indices
    regWrite(3'd0, 32'hFFFFFFFF);
    checkRead("R2 base0 mask", 3'd0);
    regWrite(3'd5, 32'hFFFFFFFF);
    checkRead("R2 map2 mask", 3'd5);
    regWrite(3'd4, 32'hFFFFFFFF);
    checkRead("R2 base2 mask", 3'd4);
    regWrite(3'd6, 32'hFFFFFFFF);
    checkRead("R2 index 6 reads zero", 3'd6);
    for (int r = 0; r < 6; r++) regWrite(3'(r), 32'h0);

    // R3 R6 R8: window 0, 256 MB at 0x40000000 -> 0x80000000, memory, low bits on
    regWrite(3'd0, 32'h40000081);
    regWrite(3'd1, 32'h00008007);
    probe("R3 window0 top byte", 32'h4FFFFFFF);
    probe("R3 window0 just above", 32'h50000000);
    probe("R6 R8 window0 mid", 32'h4123456B);
    regWrite(3'd0, 32'h40000001);
    probe("R3 code0 1MB inside", 32'h400FFFFE);
    probe("R3 code0 1MB outside", 32'h40100000);
    regWrite(3'd0, 32'h000000B9);
    probe("R3 code11 2GB with prefetch R8", 32'h7ABCDEF3);
    probe("R3 code11 2GB upper half miss", 32'h8ABCDEF3);

    // R4 reserved code and disable
    regWrite(3'd0, 32'h400000C1);
    probe("R4 code12 disabled", 32'h40000000);
    regWrite(3'd0, 32'h40000080);
    probe("R4 enable clear", 32'h40000000);

    // R7 low bits
    regWrite(3'd0, 32'h40000081);
    regWrite(3'd1, 32'h00008006);
    probe("R7 low bits forced zero", 32'h40000013);
    regWrite(3'd1, 32'h00008007);
    probe("R7 low bits passed", 32'h40000013);

    // R12 overlap and R5 priority
    regWrite(3'd2, 32'h50000089);
    regWrite(3'd3, 32'h0000000B);
    probe("R12 window1 visible at 256MB", 32'h50000010);
    regWrite(3'd0, 32'h40000091);
    probe("R5 R12 window0 enlarged hides window1", 32'h50000010);
    regWrite(3'd0, 32'h40000081);
    probe("R12 window1 visible again", 32'h50000010);

    // R9 I/O window
    regWrite(3'd4, 32'h00006001);
    regWrite(3'd5, 32'h00001202);
    probe("R9 io window low bits zero", 32'h60ABCDE3);
    regWrite(3'd5, 32'h00001203);
    probe("R9 io window low bits passed", 32'h60ABCDE3);
    probe("R9 io window miss", 32'h61000000);

    // R2 same-cycle write and request
    writeWithProbe(3'd4, 32'h0, 32'h60000004);
    probe("R2 new values after write", 32'h60000004);

    // R11 idle outputs
    @(negedge clk);
    nVec++;
    if (rspValid !== 1'b0 || rspHit !== 1'b0 || rspAddr !== 32'h0) begin
      nBad++;
      $display("FAIL R11: idle actual v=%b h=%b a=%08h expected zeros", rspValid, rspHit, rspAddr);
    end

    // Random configurations and addresses
    for (int cfgN = 0; cfgN < 40; cfgN++) begin
      for (int w = 0; w < 3; w++) begin
        logic [31:0] b;
        b = $urandom;
        b[0] = ($urandom % 5) != 0;
        regWrite(3'(2*w), b);
        regWrite(3'(2*w + 1), $urandom);
      end
      if (cfgN % 8 == 0) for (int r = 0; r < 8; r++) checkRead("R2 random readback", 3'(r));
      for (int k = 0; k < 50; k++) begin
        logic [31:0] a;
        int          pick;
        a = $urandom;
        pick = int'($urandom % 4);
        if (pick < 2) a[31:20] = shBase[pick][31:20];
        else if (pick == 2) a[31:24] = shBase[2][15:8];
        probe("R3 R5 R6 R7 R8 R9 R10 random", a);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule